// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Sequencer

This block runs one programmed-I/O transfer at a time on a parallel ATA disk channel. A host-side request carries the direction, a 3-bit register address, a choice between the command-block and control-block chip selects, a drive number and write data. The block moves through three phases: address setup, strobe, and recovery. During setup it drives the address and chip select. During the strobe phase it holds the read or write strobe low, and it stretches the strobe while the device's ready line is low. During recovery it keeps the address and chip select driven, then reports completion with the captured read data.

Phase lengths are programmed through a small configuration write port. Each of the two drives has its own data-port timing set and its own command timing set. A format bit controls how command cycles are timed. With the bit clear, command cycles use one shared timing, built phase by phase from the slower of the two drives. With the bit set, command cycles use the timing of the addressed drive. A second control bit sets the level of the drive reset line once the block is out of reset. A stuck device cannot hold the bus: the strobe is given up after a fixed number of wait clocks, and a sticky error flag is raised.

Top module: `ide_pio_seq`

## Requirements
- R1: While reset is asserted and just after it, both chip selects are high (`ata_cs_no` = 2'b11), both strobes are high, `req_ready_o` is 1, `done_o` is 0, `err_o` is 0 and `ata_rst_no` is 0.
- R2: A request is accepted on a clock where `req_valid_i` and `req_ready_o` are both 1. The first clock after acceptance starts setup. Setup lasts exactly the setup count. During setup the address and the active-low chip select are driven, and no strobe is low. `req_cs_i`=0 drives bit 0 of `ata_cs_no` low, and `req_cs_i`=1 drives bit 1 low. A read uses `ata_dior_no`, a write uses `ata_diow_no`, and the two strobes are never low together.
- R3: The ready input is sampled on the last programmed strobe clock. If it is high there, the strobe stays low for exactly the strobe count.
- R4: If ready is low at that sample point, the strobe stays low until the first clock edge at which ready is seen high. That edge releases the strobe.
- R5: After 255 wait clocks with ready still low, the strobe is released and `err_o` is set. `err_o` stays set through later cycles until reset.
- R6: After the strobe, address and chip select stay driven for exactly the recovery count. `req_ready_o` stays 0 from acceptance until recovery ends. In the first clock after recovery, `done_o` is 1 for one clock and the bus is idle.
- R7: For a read, `rdata_o` holds the value of `ata_dd_i` sampled at the edge that releases the strobe.
- R8: For a write, `ata_dd_oe_o` is 1 and `ata_dd_o` equals the request write data from the first setup clock to the last recovery clock. For a read, `ata_dd_oe_o` stays 0.
- R9: A programmed count of 0 behaves as 1 clock.
- R10: Configuration writes use 12-bit timing words laid out as setup[3:0], strobe[7:4] and recovery[11:8]. Address 2*d holds the data set of drive d, address 2*d+1 holds its command set, and address 4 holds the control word: format in bit 0, drive reset level in bit 1. The timing reset value is 4'hF per phase.
- R11: A data-port cycle is one with `req_cs_i`=0 and address 0. It uses the data set of the addressed drive, whatever the format.
- R12: With format 0, every other cycle is a command cycle. A command cycle on either drive uses, for each phase, the larger of the two drives' command counts.
- R13: With format 1, a command cycle uses the command set of the addressed drive.
- R14: After reset, `ata_rst_no` follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 12 | Configuration write data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Device register address |
| req_cs_i | input | 1 | 0 = command block select, 1 = control block select |
| req_drive_i | input | 1 | Drive whose timing is used |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Captured read data |
| err_o | output | 1 | Sticky ready-timeout flag |
| ata_addr_o | output | 3 | Device address lines |
| ata_cs_no | output | 2 | Chip selects, active low |
| ata_dior_no | output | 1 | Read strobe, active low |
| ata_diow_no | output | 1 | Write strobe, active low |
| ata_dd_o | output | 16 | Data bus out |
| ata_dd_oe_o | output | 1 | Data bus output enable |
| ata_dd_i | input | 16 | Data bus in |
| ata_iordy_i | input | 1 | Device ready |
| ata_rst_no | output | 1 | Drive reset, active low |

## Verification
The assertions assume that configuration writes happen only while the sequencer is idle. They also assume that the request fields are stable on the clock where a request is accepted, since the timing set is chosen and latched from them on that edge. The bench writes the timing and control words only between transfers. It drives request fields and the ready line at the falling edge, holds `req_valid_i` for exactly one accepting edge, and changes the ready line only at falling edges inside the strobe phase.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CNT_W = 4;
  localparam int TIM_W = 3 * CNT_W;

  // rcv at [11:8], stb at [7:4], stp at [3:0]
  typedef struct packed {
    logic [CNT_W-1:0] rcv;
    logic [CNT_W-1:0] stb;
    logic [CNT_W-1:0] stp;
  } ide_tim_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT,
    ST_RECOV
  } ide_st_e;
endpackage

// File: rtl/ide_pio_timing.sv
module ide_pio_timing
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV = 2,
  localparam int DRV_W = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
  localparam int CFG_AW = $clog2(2 * NUM_DRV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [TIM_W-1:0]  cfg_wdata_i,
  input  logic [DRV_W-1:0]  drive_i,
  input  logic              is_cmd_i,
  output ide_tim_t          tim_o,
  output logic              rst_lvl_o
);
  localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(2 * NUM_DRV);

  ide_tim_t data_q [NUM_DRV];
  ide_tim_t cmd_q  [NUM_DRV];
  logic     fmt_q;
  logic     rst_lvl_q;
  ide_tim_t slow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < NUM_DRV; d++) begin
        data_q[d] <= '1;
        cmd_q[d]  <= '1;
      end
      fmt_q     <= 1'b0;
      rst_lvl_q <= 1'b0;
    end else if (cfg_we_i) begin
      for (int d = 0; d < NUM_DRV; d++) begin
        if (cfg_addr_i == CFG_AW'(2 * d))     data_q[d] <= cfg_wdata_i;
        if (cfg_addr_i == CFG_AW'(2 * d + 1)) cmd_q[d]  <= cfg_wdata_i;
      end
      if (cfg_addr_i == CTRL_ADDR) begin
        fmt_q     <= cfg_wdata_i[0];
        rst_lvl_q <= cfg_wdata_i[1];
      end
    end
  end

  // shared command timing: per-phase maximum over all drives
  always_comb begin
    slow = cmd_q[0];
    for (int d = 1; d < NUM_DRV; d++) begin
      if (cmd_q[d].stp > slow.stp) slow.stp = cmd_q[d].stp;
      if (cmd_q[d].stb > slow.stb) slow.stb = cmd_q[d].stb;
      if (cmd_q[d].rcv > slow.rcv) slow.rcv = cmd_q[d].rcv;
    end
  end

  always_comb begin
    if (!is_cmd_i)   tim_o = data_q[drive_i];
    else if (!fmt_q) tim_o = slow;
    else             tim_o = cmd_q[drive_i];
  end

  assign rst_lvl_o = rst_lvl_q;

  // R12
  shared_ge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd_i && !fmt_q) |-> (tim_o.stp >= cmd_q[0].stp && tim_o.stb >= cmd_q[0].stb
                              && tim_o.rcv >= cmd_q[0].rcv));
endmodule

// File: rtl/ide_pio_fsm.sv
module ide_pio_fsm
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMO    = 255,
  localparam int WCW   = $clog2(TMO + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [2:0]        req_addr_i,
  input  logic              req_cs_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  ide_tim_t          tim_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [2:0]        ata_addr_o,
  output logic [1:0]        ata_cs_no,
  output logic              ata_dior_no,
  output logic              ata_diow_no,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe_o,
  input  logic [DATA_W-1:0] ata_dd_i,
  input  logic              ata_iordy_i
);
  ide_st_e           state_q;
  ide_tim_t          tim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WCW-1:0]    wcnt_q;
  logic              wr_q, cs_q, done_q, err_q;
  logic [2:0]        addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              busy, strobe;

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tim_q   <= '0;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      wr_q    <= 1'b0;
      cs_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          cs_q    <= req_cs_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          tim_q   <= tim_i;
          cnt_q   <= clamp(tim_i.stp);
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (cnt_q == CNT_W'(1)) begin
          cnt_q   <= clamp(tim_q.stb);
          state_q <= ST_STROBE;
        end else cnt_q <= cnt_q - 1'b1;
        ST_STROBE: if (cnt_q != CNT_W'(1)) cnt_q <= cnt_q - 1'b1;
          else if (ata_iordy_i) begin
            if (!wr_q) rdata_q <= ata_dd_i;
            cnt_q   <= clamp(tim_q.rcv);
            state_q <= ST_RECOV;
          end else begin
            wcnt_q  <= '0;
            state_q <= ST_WAIT;
          end
        ST_WAIT: if (ata_iordy_i || wcnt_q == WCW'(TMO - 1)) begin
            if (!wr_q) rdata_q <= ata_dd_i;
            if (!ata_iordy_i) err_q <= 1'b1;
            cnt_q   <= clamp(tim_q.rcv);
            state_q <= ST_RECOV;
          end else wcnt_q <= wcnt_q + 1'b1;
        ST_RECOV: if (cnt_q == CNT_W'(1)) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign strobe      = (state_q == ST_STROBE) || (state_q == ST_WAIT);
  assign req_ready_o = !busy;
  assign ata_addr_o  = busy ? addr_q : '0;
  assign ata_cs_no   = !busy ? 2'b11 : (cs_q ? 2'b01 : 2'b10);
  assign ata_dior_no = !(strobe && !wr_q);
  assign ata_diow_no = !(strobe && wr_q);
  assign ata_dd_o    = wdata_q;
  assign ata_dd_oe_o = busy && wr_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;

  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ata_dior_no && !ata_diow_no));
  // R2
  strobe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ata_dior_no || !ata_diow_no) |-> (ata_cs_no != 2'b11));
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ata_cs_no != 2'b11 && $past(ata_cs_no) != 2'b11) |-> $stable(ata_addr_o));
  // R6
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ata_dior_no || !ata_diow_no) |-> !req_ready_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !ata_iordy_i && wcnt_q == WCW'(TMO - 1))
      |=> (err_o && ata_dior_no && ata_diow_no));
  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8
  oe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ata_dd_oe_o |-> (ata_cs_no != 2'b11 && ata_dior_no));
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TMO    = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [11:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [2:0]        req_addr_i,
  input  logic              req_cs_i,
  input  logic              req_drive_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [2:0]        ata_addr_o,
  output logic [1:0]        ata_cs_no,
  output logic              ata_dior_no,
  output logic              ata_diow_no,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe_o,
  input  logic [DATA_W-1:0] ata_dd_i,
  input  logic              ata_iordy_i,
  output logic              ata_rst_no
);
  ide_tim_t tim_sel;
  logic     is_cmd;
  logic     rst_lvl;

  // the data port is register 0 of the command block
  assign is_cmd = req_cs_i || (req_addr_i != 3'd0);

  ide_pio_timing #(.NUM_DRV(2)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .drive_i    (req_drive_i),
    .is_cmd_i   (is_cmd),
    .tim_o      (tim_sel),
    .rst_lvl_o  (rst_lvl)
  );

  ide_pio_fsm #(.DATA_W(DATA_W), .TMO(TMO)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_cs_i   (req_cs_i),
    .req_wdata_i(req_wdata_i),
    .tim_i      (tim_sel),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .ata_addr_o (ata_addr_o),
    .ata_cs_no  (ata_cs_no),
    .ata_dior_no(ata_dior_no),
    .ata_diow_no(ata_diow_no),
    .ata_dd_o   (ata_dd_o),
    .ata_dd_oe_o(ata_dd_oe_o),
    .ata_dd_i   (ata_dd_i),
    .ata_iordy_i(ata_iordy_i)
  );

  assign ata_rst_no = rst_lvl;

  // R14
  rst_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 3'd4) |=> (ata_rst_no == $past(cfg_wdata_i[1])));
endmodule

// File: tb/tb_ide_pio_seq.sv
`timescale 1ns/1ps
module tb_ide_pio_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [11:0] cfg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [2:0]  req_addr_i = '0;
  logic        req_cs_i = 1'b0;
  logic        req_drive_i = 1'b0;
  logic [15:0] req_wdata_i = '0;
  logic        done_o;
  logic [15:0] rdata_o;
  logic        err_o;
  logic [2:0]  ata_addr_o;
  logic [1:0]  ata_cs_no;
  logic        ata_dior_no, ata_diow_no;
  logic [15:0] ata_dd_o;
  logic        ata_dd_oe_o;
  logic [15:0] ata_dd_i = '0;
  logic        ata_iordy_i = 1'b1;
  logic        ata_rst_no;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  ide_pio_seq dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  function automatic logic [11:0] tw(input int s, input int b, input int r);
    return {4'(r), 4'(b), 4'(s)};
  endfunction

  // rdy_after: 0 = ready always high, n>0 = raised after n strobe clocks, <0 = never
  task automatic run_cycle(input bit wr, input bit cs, input logic [2:0] a, input bit drv,
                           input logic [15:0] val, input int rdy_after,
                           input int e_stp, input int e_stb, input int e_rcv, input string req);
    int n_stp = 0, n_stb = 0, n_rcv = 0, guard = 0;
    bit bus_ok = 1'b1, data_ok = 1'b1, rdy_ok = 1'b1;
    logic [1:0] cs_exp = cs ? 2'b01 : 2'b10;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_cs_i = cs; req_addr_i = a;
    req_drive_i = drv; req_wdata_i = val; ata_dd_i = val;
    ata_iordy_i = (rdy_after == 0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!done_o && guard < 2000) begin
      guard++;
      if (ata_addr_o != a || ata_cs_no != cs_exp) bus_ok = 1'b0;
      if (req_ready_o) rdy_ok = 1'b0;
      if (wr ? (!ata_dd_oe_o || ata_dd_o != val || !ata_dior_no)
             : (ata_dd_oe_o || !ata_diow_no)) data_ok = 1'b0;
      if (!ata_dior_no || !ata_diow_no) begin
        n_stb++;
        if (rdy_after > 0 && n_stb == rdy_after) ata_iordy_i = 1'b1;
      end else if (n_stb == 0) n_stp++;
      else begin
        n_rcv++;
        ata_dd_i = ~val;
      end
      @(negedge clk_i);
    end
    chk(done_o, {req, " R6 done pulse"}, done_o, 1);
    chk(ata_cs_no == 2'b11, {req, " R6 idle after done"}, ata_cs_no, 3);
    chk(n_stp == e_stp, {req, " R2 setup clocks"}, n_stp, e_stp);
    chk(n_stb == e_stb, {req, " R3/R4 strobe clocks"}, n_stb, e_stb);
    chk(n_rcv == e_rcv, {req, " R6 recovery clocks"}, n_rcv, e_rcv);
    chk(bus_ok, {req, " R2 addr/cs driven"}, bus_ok, 1);
    chk(rdy_ok, {req, " R6 ready low while busy"}, rdy_ok, 1);
    chk(data_ok, {req, " R8 data bus/strobe"}, data_ok, 1);
    if (!wr) chk(rdata_o == val, {req, " R7 read data"}, rdata_o, val);
    @(negedge clk_i);
    chk(!done_o, {req, " R6 done one clock"}, done_o, 0);
    ata_iordy_i = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk(ata_cs_no == 2'b11, "R1 cs in reset", ata_cs_no, 3);
    chk(ata_rst_no == 1'b0, "R1 drive reset low in reset", ata_rst_no, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ata_dior_no && ata_diow_no, "R1 strobes high", {ata_dior_no, ata_diow_no}, 3);
    chk(req_ready_o && !done_o, "R1 ready", req_ready_o, 1);
    chk(!err_o, "R1 err clear", err_o, 0);
    chk(ata_rst_no == 1'b0, "R1 drive reset low after reset", ata_rst_no, 0);
  endtask

  task automatic t_default();
    // R10 reset timing 4'hF per phase
    run_cycle(0, 0, 3'd0, 0, 16'h1234, 0, 15, 15, 15, "R10 default");
  endtask

  task automatic t_data_port();
    cfg_wr(3'd0, tw(2, 3, 2));
    cfg_wr(3'd2, tw(1, 5, 3));
    run_cycle(0, 0, 3'd0, 0, 16'hA5C3, 0, 2, 3, 2, "R11 drv0 read");
    run_cycle(1, 0, 3'd0, 1, 16'h5A3C, 0, 1, 5, 3, "R11 drv1 write");
  endtask

  task automatic t_zero();
    cfg_wr(3'd0, tw(0, 0, 0));
    run_cycle(0, 0, 3'd0, 0, 16'h0F0F, 0, 1, 1, 1, "R9 zero counts");
    run_cycle(1, 0, 3'd0, 0, 16'hF0F0, 0, 1, 1, 1, "R9 zero write");
  endtask

  task automatic t_format0();
    cfg_wr(3'd1, tw(2, 2, 2));
    cfg_wr(3'd3, tw(5, 1, 4));
    cfg_wr(3'd4, 12'h000);
    run_cycle(0, 0, 3'd7, 0, 16'h0077, 0, 5, 2, 4, "R12 fmt0 drv0 cmd");
    run_cycle(1, 1, 3'd6, 1, 16'h0066, 0, 5, 2, 4, "R12 fmt0 drv1 ctl");
    run_cycle(0, 0, 3'd0, 1, 16'h1111, 0, 1, 5, 3, "R11 fmt0 data");
  endtask

  task automatic t_format1();
    cfg_wr(3'd4, 12'h001);
    run_cycle(0, 0, 3'd7, 0, 16'h2222, 0, 2, 2, 2, "R13 fmt1 drv0 cmd");
    run_cycle(1, 1, 3'd6, 1, 16'h3333, 0, 5, 1, 4, "R13 fmt1 drv1 ctl");
    run_cycle(0, 0, 3'd0, 1, 16'h4444, 0, 1, 5, 3, "R11 fmt1 data");
  endtask

  task automatic t_iordy();
    cfg_wr(3'd0, tw(1, 3, 1));
    run_cycle(0, 0, 3'd0, 0, 16'hBEEF, 7, 1, 7, 1, "R4 wait states");
    run_cycle(0, 0, 3'd0, 0, 16'hCAFE, 2, 1, 3, 1, "R3 ready before sample");
    run_cycle(1, 0, 3'd0, 0, 16'hD00D, 4, 1, 4, 1, "R4 wait one clock");
    chk(!err_o, "R5 no err on normal waits", err_o, 0);
  endtask

  task automatic t_timeout();
    cfg_wr(3'd0, tw(1, 2, 1));
    run_cycle(0, 0, 3'd0, 0, 16'h7E57, -1, 1, 257, 1, "R5 timeout");
    chk(err_o, "R5 err set", err_o, 1);
    run_cycle(0, 0, 3'd0, 0, 16'h1357, 0, 1, 2, 1, "R5 after timeout");
    chk(err_o, "R5 err sticky", err_o, 1);
  endtask

  task automatic t_drv_rst();
    cfg_wr(3'd4, 12'h002);
    #1;
    chk(ata_rst_no == 1'b1, "R14 drive reset high", ata_rst_no, 1);
    cfg_wr(3'd4, 12'h000);
    #1;
    chk(ata_rst_no == 1'b0, "R14 drive reset low", ata_rst_no, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_default();
    t_data_port();
    t_zero();
    t_format0();
    t_format1();
    t_iordy();
    t_drv_rst();
    t_timeout();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule